// File: doc/BRIEF.md
# Recirculating Waveform Address Sequencer

This block produces the read address for a waveform memory that plays back in an endless loop. Eight profiles each hold a first address, a last address and a dwell interval in clock cycles. The chosen profile's address runs upward from its first address. It moves by one each time an internal down-counting interval timer runs out. Once the last address has been reached, the next expiry puts the address back at the first address, and the loop continues.

Playback restarts from the selected profile's first address in three cases: after reset, on an update strobe, and whenever the registered profile select changes value. A one-bit end-of-pass flag goes high for two cycles each time the address arrives at the last address. A system uses the address output to index its waveform memory and the flag to mark each completed pass.

Top module: `wave_addr_loop`

## Requirements
- R1: Between restarts, the address moves up by exactly one on each timer expiry and holds in all other cycles. The timer expires once every `step` cycles, counted from the restart edge.
- R2: On the expiry that follows a cycle in which the address equals the profile's last address, the address is loaded with the profile's first address.
- R3: Looping goes on for any number of passes, with no strobe needed, until an update strobe arrives or the select changes.
- R4: The per-profile no-dwell bits have no effect on the address or flag sequence.
- R5: A change on `sel_i` is registered and detected against its previous value. On the second rising edge after the change is presented, the address loads the new profile's first address and the timer restarts.
- R6: A clock edge that samples `upd_i` high loads the selected profile's first address, reloads the timer and forces `eos_o` low in the next cycle.
- R7: On the edge where the address becomes the last address, `eos_o` rises and stays high for exactly two cycles.
- R8: A step interval of 0 behaves exactly like a step interval of 1.
- R9: When the first and last addresses are equal, the address holds at that value, and `eos_o` pulses for two cycles after each timer expiry.
- R10: If the last address is reached again while `eos_o` is high, the two-cycle pulse restarts and is not lengthened further. With a step of 1 and first equal to last, the flag stays high continuously after the first expiry.
- R11: During reset, `addr_o` is 0 and `eos_o` is 0. The first edge after reset loads profile 0's first address (the registered select resets to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Update strobe, restarts the loop |
| sel_i | input | 3 | Profile select |
| prof_start_i | input | 80 | First address of each profile, profile n in bits [10n+9:10n] |
| prof_end_i | input | 80 | Last address of each profile, same packing |
| prof_step_i | input | 128 | Dwell interval of each profile in cycles, profile n in bits [16n+15:16n] |
| prof_nodwell_i | input | 8 | No-dwell bit of each profile, ignored |
| addr_o | output | 10 | Waveform memory read address |
| eos_o | output | 1 | End-of-pass flag |

## Verification
A corrupted interval timer shows on `addr_o` within one dwell interval, because steps arrive early, late or not at all. A wrong wrap decision shows on the first pass as an address that either runs past the last address or skips back too early. A stale select register or a stuck flag counter appears at the ports within two cycles of a select change or an update strobe. At that point either the first address or a low `eos_o` is expected. Every cycle of several full loops is compared against a closed-form expectation, so any of these faults is visible at the ports within one loop period.

// File: rtl/wave_addr_loop.sv
module wave_addr_loop #(
  parameter int NPROF = 8,
  parameter int AW    = 10,
  parameter int TW    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_i,
  input  logic [2:0]         sel_i,
  input  logic [NPROF*AW-1:0] prof_start_i,
  input  logic [NPROF*AW-1:0] prof_end_i,
  input  logic [NPROF*TW-1:0] prof_step_i,
  input  logic [NPROF-1:0]   prof_nodwell_i,
  output logic [AW-1:0]      addr_o,
  output logic               eos_o
);
  localparam int SW = $clog2(NPROF);

  logic [SW-1:0] sel_q, sel_prev;
  logic          started;
  logic [AW-1:0] addr;
  logic [TW-1:0] tmr;
  logic [1:0]    fcnt;

  logic [AW-1:0] cur_start, cur_end, nxt;
  logic [TW-1:0] cur_step, cur_stepm1;
  logic          chg, restart, tick;
  logic          unused_nodwell;

  assign cur_start  = prof_start_i[int'(sel_q)*AW +: AW];
  assign cur_end    = prof_end_i[int'(sel_q)*AW +: AW];
  assign cur_step   = prof_step_i[int'(sel_q)*TW +: TW];
  assign cur_stepm1 = (cur_step == '0) ? '0 : cur_step - TW'(1);

  assign chg     = started && (sel_q != sel_prev);
  assign restart = upd_i || chg || !started;
  assign tick    = (tmr == '0);
  assign nxt     = (addr == cur_end) ? cur_start : addr + AW'(1);

  assign unused_nodwell = ^prof_nodwell_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      sel_prev <= '0;
      started  <= 1'b0;
      addr     <= '0;
      tmr      <= '0;
      fcnt     <= '0;
    end else begin
      sel_q    <= sel_i[SW-1:0];
      sel_prev <= sel_q;
      started  <= 1'b1;
      if (restart) begin
        addr <= cur_start;
        tmr  <= cur_stepm1;
        fcnt <= '0;
      end else if (tick) begin
        addr <= nxt;
        tmr  <= cur_stepm1;
        if (nxt == cur_end)   fcnt <= 2'd2;
        else if (fcnt != '0) fcnt <= fcnt - 2'd1;
      end else begin
        tmr <= tmr - TW'(1);
        if (fcnt != '0) fcnt <= fcnt - 2'd1;
      end
    end
  end

  assign addr_o = addr;
  assign eos_o  = (fcnt != '0);

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(addr_o)); // R1
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && tick && addr_o != cur_end) |=> (addr_o == $past(addr_o) + AW'(1))); // R1
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && tick && addr_o == cur_end) |=> (addr_o == $past(cur_start))); // R2
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (addr_o == $past(cur_start))); // R6
  AST_RESTART_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !eos_o); // R6
  AST_FLAG_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eos_o) && !restart) |=> eos_o); // R7
  AST_FLAG_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos_o) |-> (addr_o == cur_end)); // R7
endmodule

// File: tb/wave_addr_loop_bench.sv
module wave_addr_loop_bench;
  localparam int NP = 8, AW = 10, TW = 16;

  logic clk = 1'b0, rst_n = 1'b0, upd = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [NP*AW-1:0] pstart = '0, pend = '0;
  logic [NP*TW-1:0] pstep = '0;
  logic [NP-1:0] pnd = '0;
  logic [AW-1:0] addr;
  logic eos;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wave_addr_loop u_wave_addr_loop (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .sel_i(sel),
    .prof_start_i(pstart), .prof_end_i(pend), .prof_step_i(pstep),
    .prof_nodwell_i(pnd), .addr_o(addr), .eos_o(eos));

  typedef struct packed {
    logic [2:0]  sel;
    logic [9:0]  first;
    logic [9:0]  last;
    logic [15:0] step;
    logic        nd;
    logic [15:0] cycles;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 10'd5,    10'd9,    16'd3, 1'b0, 16'd45},
    '{3'd3, 10'd100,  10'd103,  16'd1, 1'b0, 16'd20},
    '{3'd5, 10'd20,   10'd22,   16'd0, 1'b1, 16'd15},
    '{3'd7, 10'd50,   10'd50,   16'd4, 1'b0, 16'd20},
    '{3'd2, 10'd7,    10'd7,    16'd1, 1'b0, 16'd10},
    '{3'd6, 10'd1020, 10'd1023, 16'd2, 1'b0, 16'd30}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R1 R2 R3 R7";
      1: return "R1 R7";
      2: return "R8 R4";
      3: return "R9";
      4: return "R10";
      default: return "R2 R3";
    endcase
  endfunction

  function automatic int exp_addr(int f, int l, int st, int t);
    int s = (st == 0) ? 1 : st;
    int len = l - f + 1;
    return (f + ((t / s) % len)) & ((1 << AW) - 1);
  endfunction

  function automatic bit exp_eos(int f, int l, int st, int t);
    int s = (st == 0) ? 1 : st;
    int len = l - f + 1;
    int k = t / s, ph = t % s;
    return (k >= 1 && ph < 2 && (k % len) == len - 1) ||
           (s == 1 && k >= 2 && ((k - 1) % len) == len - 1);
  endfunction

  task automatic set_prof(int i, int f, int l, int st);
    pstart[i*AW +: AW] = AW'(f);
    pend[i*AW +: AW]   = AW'(l);
    pstep[i*TW +: TW]  = TW'(st);
  endtask

  task automatic chk(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic run_check(string tag, int f, int l, int st, int n);
    for (int t = 0; t < n; t++) begin
      chk(tag, int'(addr), exp_addr(f, l, st, t));
      chk(tag, int'(eos), int'(exp_eos(f, l, st, t)));
      @(negedge clk);
    end
  endtask

  task automatic pulse_upd();
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) set_prof(int'(VEC[i].sel), int'(VEC[i].first), int'(VEC[i].last), int'(VEC[i].step));
    repeat (3) @(negedge clk);
    chk("R11 reset addr", int'(addr), 0);
    chk("R11 reset flag", int'(eos), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_check("R11 first load", 5, 9, 3, 8);

    for (int i = 0; i < 6; i++) begin
      sel = VEC[i].sel;
      pnd = VEC[i].nd ? '1 : '0;
      repeat (4) @(negedge clk);
      pulse_upd();
      run_check(tag_of(i), int'(VEC[i].first), int'(VEC[i].last), int'(VEC[i].step), int'(VEC[i].cycles));
    end
    pnd = '0;

    // R5: select change mid-loop restarts from new profile
    sel = 3'd0;
    repeat (4) @(negedge clk);
    pulse_upd();
    repeat (7) @(negedge clk);
    sel = 3'd3;
    @(negedge clk);
    @(negedge clk);
    run_check("R5 profile change", 100, 103, 1, 10);

    // R6: update while flag high forces it low and reloads start
    pulse_upd();
    repeat (3) @(negedge clk);
    chk("R6 flag before", int'(eos), 1);
    chk("R6 addr before", int'(addr), 103);
    pulse_upd();
    chk("R6 addr reload", int'(addr), 100);
    chk("R6 flag low", int'(eos), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule